// File: doc/BRIEF.md
# Push-Button Press Messenger

This block turns presses on four push-buttons into short messages on the transmit side of a FIFO-based network wrapper. Every raw button line is brought into the clock domain through a two-flop synchronizer. A counter then filters out contact bounce. Only the transition from released to pressed is treated as an event. Events wait in a pending mask until the sender can take them.

Each message has two words. The first word carries the destination address and is flagged by `av_out`. The second word carries a mask of the buttons that became pressed. A word is written in any cycle where `we_out` is high. In that same cycle the command code 0x02 appears on `comm_out` and the word appears on `data_out`. The block never writes while the wrapper reports that its FIFO is full. Presses that arrive while a message is in flight are merged into the next message.

The destination address is a parameter. Different addresses inside one receiver can therefore select different channels.

Top module: `btn_event_sender`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `we_out`, `av_out`, `comm_out` and `data_out` are all zero.
- R2: In any cycle with `we_out` low, `av_out`, `comm_out` and `data_out` are all zero.
- R3: In every cycle with `we_out` high, `comm_out` equals 0x02.
- R4: A message is an address word followed directly, in write order, by a payload word. The address word has `av_out` high and `data_out` equal to the `DEST_ADDR` parameter. The payload word has `av_out` low.
- R5: Bit i of the payload (i = 0..3) is set when button i was newly pressed. Bits 4 and above are zero.
- R6: No word is written in a cycle where `full_in` is high. A message stalled by `full_in` resumes intact once `full_in` drops.
- R7: A change of a button's synchronized level takes effect only after it has held for `DEBOUNCE_CYC` consecutive cycles. A raw pulse shorter than that produces no message.
- R8: A button line is active-low (0 = pressed). Only a released-to-pressed transition produces an event. Holding a button down or releasing it sends nothing.
- R9: Presses detected while a message is pending or in flight are collected and sent in a later message. Every press is reported exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| btnN | input | 4 | Raw push-button lines, active low |
| full_in | input | 1 | Transmit FIFO full flag from the wrapper |
| av_out | output | 1 | Marks the address word of a message |
| comm_out | output | 5 | Command code, 0x02 on a write, 0x00 otherwise |
| data_out | output | 32 | Address or payload word |
| we_out | output | 1 | Write enable toward the wrapper FIFO |

## Verification
Two things can fall in the same cycle: a newly debounced press, and the load that hands the pending mask to the sender. If the block were careless, that press could be lost or reported twice. The bench provokes this collision by pressing a second button at every offset from 0 to well past the debounce window after the first press. One of those offsets lands exactly on the load cycle. It also runs the collision with the FIFO held full, so the second press must wait behind a stalled message. A run passes when the payloads seen on the port together cover both buttons and each button appears exactly once.

// File: rtl/bes_pkg.sv
package bes_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2
  } sendState_e;

  typedef struct packed {
    logic load;
    logic drvAddr;
    logic drvData;
  } ctrlStrobe_t;
endpackage

// File: rtl/bes_debounce.sv
module bes_debounce #(
  parameter int DEBOUNCE_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rawN,
  output logic pressPulse
);
  localparam int CNT_W = $clog2(DEBOUNCE_CYC + 1);
  localparam logic [CNT_W-1:0] LIM = CNT_W'(DEBOUNCE_CYC - 1);

  logic [1:0] syncQ;
  logic syncLvl;
  logic stableQ;
  logic [CNT_W-1:0] cntQ;

  assign syncLvl = ~syncQ[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      syncQ <= 2'b11;
    end else begin
      syncQ <= {syncQ[0], rawN};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stableQ <= 1'b0;
      cntQ    <= '0;
    end else if (syncLvl != stableQ) begin
      if (cntQ == LIM) begin
        stableQ <= syncLvl;
        cntQ    <= '0;
      end else begin
        cntQ <= cntQ + 1'b1;
      end
    end else begin
      cntQ <= '0;
    end
  end

  assign pressPulse = syncLvl & ~stableQ & (cntQ == LIM);

  // R7
  settle_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stableQ != $past(stableQ)) |-> (stableQ == $past(syncLvl)));
endmodule

// File: rtl/bes_datapath.sv
module bes_datapath import bes_pkg::*; #(
  parameter int NUM_BTN = 4,
  parameter int DATA_W = 32,
  parameter int COMM_W = 5,
  parameter int DEBOUNCE_CYC = 16,
  parameter logic [DATA_W-1:0] DEST_ADDR = 'h300,
  parameter logic [COMM_W-1:0] SEND_CMD = 'h2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic [NUM_BTN-1:0] btnN,
  input  logic fullIn,
  input  ctrlStrobe_t strb,
  output logic pendAny,
  output logic weOut,
  output logic avOut,
  output logic [COMM_W-1:0] commOut,
  output logic [DATA_W-1:0] dataOut
);
  localparam int PAD_W = DATA_W - NUM_BTN;

  logic [NUM_BTN-1:0] pulses;
  logic [NUM_BTN-1:0] pendQ;
  logic [NUM_BTN-1:0] payloadQ;

  for (genvar b = 0; b < NUM_BTN; b++) begin : g_btn
    bes_debounce #(.DEBOUNCE_CYC(DEBOUNCE_CYC)) u_deb (
      .clk(clk),
      .rst_n(rst_n),
      .rawN(btnN[b]),
      .pressPulse(pulses[b])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pendQ    <= '0;
      payloadQ <= '0;
    end else if (strb.load) begin
      payloadQ <= pendQ;
      pendQ    <= pulses;
    end else begin
      pendQ <= pendQ | pulses;
    end
  end

  assign pendAny = |pendQ;
  assign weOut   = strb.drvAddr | strb.drvData;
  assign avOut   = strb.drvAddr;
  assign commOut = weOut ? SEND_CMD : '0;

  always_comb begin
    dataOut = '0;
    if (strb.drvAddr) dataOut = DEST_ADDR;
    else if (strb.drvData) dataOut = {{PAD_W{1'b0}}, payloadQ};
  end

  // R6
  no_write_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    weOut |-> !fullIn);
  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !weOut |-> (commOut == '0 && !avOut && dataOut == '0));
  // R3
  cmd_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    weOut |-> (commOut == SEND_CMD));
  // R9
  pend_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.load |=> ((pendQ & $past(pendQ)) == $past(pendQ)));
endmodule

// File: rtl/bes_control.sv
module bes_control import bes_pkg::*; (
  input  logic clk,
  input  logic rst_n,
  input  logic fullIn,
  input  logic pendAny,
  output ctrlStrobe_t strb
);
  sendState_e stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE: if (pendAny) stateD = ST_ADDR;
      ST_ADDR: if (!fullIn) stateD = ST_DATA;
      ST_DATA: if (!fullIn) stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stateQ <= ST_IDLE;
    else        stateQ <= stateD;
  end

  assign strb.load    = (stateQ == ST_IDLE) && pendAny;
  assign strb.drvAddr = (stateQ == ST_ADDR) && !fullIn;
  assign strb.drvData = (stateQ == ST_DATA) && !fullIn;

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stateQ != ST_IDLE && fullIn) |=> $stable(stateQ));
  // R4
  addr_then_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.drvAddr |=> (stateQ == ST_DATA));
endmodule

// File: rtl/btn_event_sender.sv
module btn_event_sender import bes_pkg::*; #(
  parameter int NUM_BTN = 4,
  parameter int DATA_W = 32,
  parameter int COMM_W = 5,
  parameter int DEBOUNCE_CYC = 50000,
  parameter logic [DATA_W-1:0] DEST_ADDR = 'h300,
  parameter logic [COMM_W-1:0] SEND_CMD = 'h2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic [NUM_BTN-1:0] btnN,
  input  logic full_in,
  output logic av_out,
  output logic [COMM_W-1:0] comm_out,
  output logic [DATA_W-1:0] data_out,
  output logic we_out
);
  ctrlStrobe_t strb;
  logic pendAny;

  bes_control u_ctrl (
    .clk(clk),
    .rst_n(rst_n),
    .fullIn(full_in),
    .pendAny(pendAny),
    .strb(strb)
  );

  bes_datapath #(
    .NUM_BTN(NUM_BTN),
    .DATA_W(DATA_W),
    .COMM_W(COMM_W),
    .DEBOUNCE_CYC(DEBOUNCE_CYC),
    .DEST_ADDR(DEST_ADDR),
    .SEND_CMD(SEND_CMD)
  ) u_dp (
    .clk(clk),
    .rst_n(rst_n),
    .btnN(btnN),
    .fullIn(full_in),
    .strb(strb),
    .pendAny(pendAny),
    .weOut(we_out),
    .avOut(av_out),
    .commOut(comm_out),
    .dataOut(data_out)
  );
endmodule

// File: tb/btn_event_sender_bench.sv
module btn_event_sender_bench;
  localparam int DW = 16;
  localparam int DEB = 4;
  localparam logic [DW-1:0] DEST = 16'h0A5C;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] btnN = 4'hF;
  logic full_in = 1'b0;
  logic av_out;
  logic [4:0] comm_out;
  logic [DW-1:0] data_out;
  logic we_out;

  int nCmp = 0;
  int nBad = 0;
  logic [DW-1:0] rxQ[$];
  logic expectData = 1'b0;

  always #2 clk = ~clk;

  btn_event_sender #(
    .NUM_BTN(4), .DATA_W(DW), .COMM_W(5), .DEBOUNCE_CYC(DEB), .DEST_ADDR(DEST), .SEND_CMD(5'h02)
  ) u_btn_event_sender (
    .clk(clk), .rst_n(rst_n), .btnN(btnN), .full_in(full_in),
    .av_out(av_out), .comm_out(comm_out), .data_out(data_out), .we_out(we_out)
  );

  task automatic check(input logic ok, input string req, input longint act, input longint exp);
    nCmp++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // port monitor: samples 1 ns after the falling edge, i.e. the word written at the next rising edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rst_n) begin
        if (we_out) begin
          check(!full_in, "R6 write while full", {63'd0, full_in}, 0);
          check(comm_out == 5'h02, "R3 command code", comm_out, 2);
          if (av_out) begin
            check(data_out == DEST && !expectData, "R4 address word", data_out, DEST);
            expectData = 1'b1;
          end else begin
            check(expectData, "R4 payload without address", 0, 1);
            check(data_out[DW-1:4] == '0, "R5 upper payload bits", data_out, data_out & 16'hF);
            expectData = 1'b0;
            rxQ.push_back(data_out);
          end
        end else if (av_out || comm_out != 0 || data_out != 0) begin
          check(1'b0, "R2 idle outputs", {av_out, comm_out, data_out}, 0);
        end
      end
    end
  end

  task automatic expectMsgs(input int cnt, input logic [3:0] m0, input logic [3:0] m1, input string req);
    check(rxQ.size() == cnt, req, rxQ.size(), cnt);
    if (cnt > 0 && rxQ.size() > 0) check(rxQ[0] == {12'd0, m0}, req, rxQ[0], m0);
    if (cnt > 1 && rxQ.size() > 1) check(rxQ[1] == {12'd0, m1}, req, rxQ[1], m1);
    rxQ.delete();
  endtask

  initial begin
    #(4 * 150000);
    nBad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    tick(1);
    // R1 reset state
    check(!we_out && !av_out && comm_out == 0 && data_out == 0, "R1 outputs in reset", we_out, 0);
    tick(3);
    rst_n = 1'b1;
    #1;
    check(!we_out && !av_out && comm_out == 0 && data_out == 0, "R1 outputs after reset", we_out, 0);
    tick(10);

    // R5 / R8: every non-empty simultaneous press pattern, then release and hold
    for (int m = 1; m < 16; m++) begin
      btnN = ~4'(m);
      tick(20);
      expectMsgs(1, 4'(m), 0, "R5 pressed mask");
      btnN = 4'hF;
      tick(20);
      expectMsgs(0, 0, 0, "R8 release or hold sends nothing");
    end

    // R7: pulses shorter than the window are ignored, exact window is accepted
    for (int w = 1; w < DEB; w++) begin
      btnN = 4'b1011;
      tick(w);
      btnN = 4'hF;
      tick(20);
      expectMsgs(0, 0, 0, "R7 short glitch ignored");
    end
    btnN = 4'b1011;
    tick(DEB);
    btnN = 4'hF;
    tick(25);
    expectMsgs(1, 4'b0100, 0, "R7 window-length press accepted");

    // R6: full held high blocks everything, then message resumes
    full_in = 1'b1;
    btnN = 4'b1110;
    tick(40);
    expectMsgs(0, 0, 0, "R6 no message while full");
    full_in = 1'b0;
    tick(10);
    expectMsgs(1, 4'b0001, 0, "R6 resume after full drops");
    btnN = 4'hF;
    tick(20);

    // R6: full toggling every cycle during a message
    btnN = 4'b0111;
    for (int c = 0; c < 40; c++) begin
      full_in = c[0];
      tick(1);
    end
    full_in = 1'b0;
    tick(5);
    expectMsgs(1, 4'b1000, 0, "R6 toggling full keeps message intact");
    btnN = 4'hF;
    tick(20);

    // R9: second press swept across every offset, including the load cycle
    for (int off = 0; off < DEB + 12; off++) begin
      logic [3:0] uni;
      int ones;
      btnN = 4'b1110;
      tick(off);
      btnN = 4'b1100;
      tick(30);
      uni = 0;
      ones = 0;
      foreach (rxQ[k]) begin
        uni = uni | rxQ[k][3:0];
        ones += $countones(rxQ[k][3:0]);
      end
      check(uni == 4'b0011 && ones == 2 && rxQ.size() >= 1 && rxQ.size() <= 2,
            "R9 each press reported once", {uni, 8'(ones)}, {4'b0011, 8'd2});
      rxQ.delete();
      btnN = 4'hF;
      tick(20);
      expectMsgs(0, 0, 0, "R9 nothing after release");
    end

    // R9: press accumulated behind a stalled message
    full_in = 1'b1;
    btnN = 4'b1110;
    tick(20);
    btnN = 4'b1100;
    tick(20);
    full_in = 1'b0;
    tick(20);
    expectMsgs(2, 4'b0001, 4'b0010, "R9 pending press sent next");
    btnN = 4'hF;
    tick(20);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule